// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block is a synchronous controller that performs write cycles on an external asynchronous static RAM. The write-enable strobe controls each cycle. A client hands over one request at a time, a 17-bit address and an 8-bit data word, through a valid/ready port. The block then registers and drives the memory pins: the address bus, a low-active and a high-active chip enable, write enable, output enable, and the data word together with its drive-enable for an external tri-state buffer.

The memory only writes while its low-active enable is low, its high-active enable is high and write enable is low. The write ends on whichever of these three goes inactive first. In this design that is always the rising edge of write enable, and every setup and hold figure is timed against that edge. Each phase length is a parameter in nanoseconds. At elaboration it is rounded up to whole clocks of the `CLK_PERIOD_NS` period. Output enable is held high at all times. The data drivers stay off until the memory's output has had its float time after write enable falls.

Back-pressure rules: a request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when no write is in progress, which means the idle state or the single completion cycle. While `in_ready` is low, `in_addr`, `in_data` and `in_valid` are ignored. A client that keeps `in_valid` high through the completion cycle has its next request taken straight away, with one cycle of inactive chip enables between the two writes.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, the pin levels are mem_ce_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and wr_done=0, and in_ready=1.
- R2: A request is accepted only on a clock edge with in_valid=1 and in_ready=1. in_ready is 0 from the edge that accepts a request until the completion cycle. Input changes while in_ready=0 leave every memory pin unchanged, and they start no write.
- R3: The edge after acceptance drives the address, sets mem_ce_n=0 and mem_ce=1, and keeps mem_we_n=1. This state lasts NA = max(1, ceil(ADDR_LEAD_NS/CLK_PERIOD_NS)) cycles before mem_we_n falls.
- R4: mem_we_n stays 0 for NW cycles. NW = max(ceil(WE_PULSE_NS/T), NZ+ND, ceil(ADDR_TO_END_NS/T)−NA), where T=CLK_PERIOD_NS, NZ = ceil(FLOAT_NS/T) and ND = max(1, ceil(DATA_SETUP_NS/T)).
- R5: mem_dq_oe rises exactly NZ cycles after mem_we_n falls. It stays 1 for the rest of the low pulse, that is NW−NZ ≥ ND cycles, and for NH = ceil(DATA_HOLD_NS/T) cycles after mem_we_n rises. mem_dq_out equals the accepted data while mem_dq_oe=1.
- R6: After mem_we_n rises, the address and both chip enables stay asserted for NR cycles. NR = max(1, ceil(ADDR_HOLD_NS/T), NH, ceil(CYCLE_MIN_NS/T)−NA−NW).
- R7: mem_we_n is 0 only while mem_ce_n=0 and mem_ce=1. The chip enables and the address never change on the edge where mem_we_n rises.
- R8: mem_oe_n is 1 in every cycle.
- R9: In the cycle after recovery, wr_done=1 for exactly one cycle, both chip enables are inactive and in_ready=1. A request presented in that cycle starts its address phase on the next edge.
- R10: mem_addr equals the accepted address and does not change in any cycle where the chip enables are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic on the rising edge |
| rst_n | input | 1 | Synchronous reset, low active |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | 17 | Write address |
| in_data | input | 8 | Write data |
| mem_addr | output | 17 | Registered address bus to the memory |
| mem_ce_n | output | 1 | Low-active chip enable |
| mem_ce | output | 1 | High-active chip enable |
| mem_we_n | output | 1 | Low-active write enable |
| mem_oe_n | output | 1 | Low-active output enable, held high |
| mem_dq_out | output | 8 | Data to the bus buffer |
| mem_dq_oe | output | 1 | Drive enable for the bus buffer |
| wr_done | output | 1 | One-cycle pulse when a write completes |

## Verification
The bench builds two instances. The first uses the default parameters, the fastest grade at a 20 ns period, which gives NA=1, NZ=1, NW=3 (set by float plus data setup), NH=0 and NR=1. The second uses the slowest grade figures with a 10 ns period, a 120 ns cycle minimum and a 15 ns data hold, which gives NA=1, NZ=3, NW=6, NH=2 and NR=5. With these values the bench reaches a recovery phase stretched by the cycle minimum, data driven past the write-enable rise, and a multi-cycle float wait, none of which the default values reach.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WLOW  = 3'd2,
    ST_RECOV = 3'd3,
    ST_DONE  = 3'd4
  } sws_state_e;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sws_req_hold.sv
module sws_req_hold #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data
);

  // The hold registers feed the pins directly, so address and data are
  // registered outputs that change only on an accepting edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_addr <= '0;
      hold_data <= '0;
    end else if (accept) begin
      hold_addr <= in_addr;
      hold_data <= in_data;
    end
  end

endmodule

// File: rtl/sws_phase_fsm.sv
module sws_phase_fsm
  import sws_pkg::*;
#(
  parameter int N_AS  = 1,
  parameter int N_WE  = 3,
  parameter int N_REC = 1,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             accept,
  output sws_state_e       nxt_state,
  output logic [CNT_W-1:0] nxt_cnt
);

  localparam logic [CNT_W-1:0] LAST_AS  = CNT_W'(N_AS - 1);
  localparam logic [CNT_W-1:0] LAST_WE  = CNT_W'(N_WE - 1);
  localparam logic [CNT_W-1:0] LAST_REC = CNT_W'(N_REC - 1);

  sws_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign in_ready = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign accept   = in_ready && in_valid;

  always_comb begin
    nxt_state = state_q;
    nxt_cnt   = cnt_q + 1'b1;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        nxt_cnt   = '0;
        nxt_state = accept ? ST_ADDR : ST_IDLE;
      end
      ST_ADDR: begin
        if (cnt_q == LAST_AS) begin
          nxt_state = ST_WLOW;
          nxt_cnt   = '0;
        end
      end
      ST_WLOW: begin
        if (cnt_q == LAST_WE) begin
          nxt_state = ST_RECOV;
          nxt_cnt   = '0;
        end
      end
      ST_RECOV: begin
        if (cnt_q == LAST_REC) begin
          nxt_state = ST_DONE;
          nxt_cnt   = '0;
        end
      end
      default: begin
        nxt_state = ST_IDLE;
        nxt_cnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= nxt_state;
      cnt_q   <= nxt_cnt;
    end
  end

endmodule

// File: rtl/sws_pin_drive.sv
module sws_pin_drive
  import sws_pkg::*;
#(
  parameter int N_HZ  = 1,
  parameter int N_HD  = 0,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sws_state_e       nxt_state,
  input  logic [CNT_W-1:0] nxt_cnt,
  output logic             mem_ce_n,
  output logic             mem_ce,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic             mem_dq_oe,
  output logic             wr_done
);

  logic sel_act;
  logic drive_d;

  // Every strobe is a flop of its own, loaded from the decoded next
  // state, so no decode hazard reaches a pin.
  assign sel_act = (nxt_state == ST_ADDR) || (nxt_state == ST_WLOW) ||
                   (nxt_state == ST_RECOV);
  assign drive_d = ((nxt_state == ST_WLOW)  && (int'(nxt_cnt) >= N_HZ)) ||
                   ((nxt_state == ST_RECOV) && (int'(nxt_cnt) <  N_HD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_ce    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      wr_done   <= 1'b0;
    end else begin
      mem_ce_n  <= !sel_act;
      mem_ce    <= sel_act;
      mem_we_n  <= (nxt_state != ST_WLOW);
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= drive_d;
      wr_done   <= (nxt_state == ST_DONE);
    end
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sws_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int CLK_PERIOD_NS  = 20,
  parameter int CYCLE_MIN_NS   = 45,
  parameter int ADDR_LEAD_NS   = 0,
  parameter int ADDR_TO_END_NS = 35,
  parameter int WE_PULSE_NS    = 35,
  parameter int DATA_SETUP_NS  = 25,
  parameter int DATA_HOLD_NS   = 0,
  parameter int ADDR_HOLD_NS   = 0,
  parameter int FLOAT_NS       = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              wr_done
);

  localparam int T     = CLK_PERIOD_NS;
  localparam int N_AS  = imax(1, ns_to_cyc(ADDR_LEAD_NS, T));
  localparam int N_HZ  = ns_to_cyc(FLOAT_NS, T);
  localparam int N_SD  = imax(1, ns_to_cyc(DATA_SETUP_NS, T));
  localparam int N_WE  = imax(imax(ns_to_cyc(WE_PULSE_NS, T), N_HZ + N_SD),
                              ns_to_cyc(ADDR_TO_END_NS, T) - N_AS);
  localparam int N_HD  = ns_to_cyc(DATA_HOLD_NS, T);
  localparam int N_REC = imax(imax(1, ns_to_cyc(ADDR_HOLD_NS, T)),
                              imax(N_HD, ns_to_cyc(CYCLE_MIN_NS, T) - N_AS - N_WE));
  localparam int N_MAX = imax(imax(N_AS, N_WE), N_REC);
  localparam int CNT_W = $clog2(N_MAX + 1);

  if (CLK_PERIOD_NS < 1) begin : g_bad_period
    $error("sram_wr_seq: clock period must be positive");
  end
  if (WE_PULSE_NS > 0 && N_WE < 1) begin : g_bad_we
    $error("sram_wr_seq: write pulse rounds to zero cycles");
  end
  if (DATA_SETUP_NS > 0 && N_WE - N_HZ < 1) begin : g_bad_sd
    $error("sram_wr_seq: no cycle left for data setup");
  end
  if (DATA_HOLD_NS > 0 && N_HD < 1) begin : g_bad_hd
    $error("sram_wr_seq: data hold rounds to zero cycles");
  end

  logic             accept;
  sws_state_e       nxt_state;
  logic [CNT_W-1:0] nxt_cnt;

  sws_phase_fsm #(
    .N_AS  (N_AS),
    .N_WE  (N_WE),
    .N_REC (N_REC),
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .nxt_state (nxt_state),
    .nxt_cnt   (nxt_cnt)
  );

  sws_req_hold #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .in_addr   (in_addr),
    .in_data   (in_data),
    .hold_addr (mem_addr),
    .hold_data (mem_dq_out)
  );

  sws_pin_drive #(
    .N_HZ  (N_HZ),
    .N_HD  (N_HD),
    .CNT_W (CNT_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_state (nxt_state),
    .nxt_cnt   (nxt_cnt),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .wr_done   (wr_done)
  );

endmodule

// File: rtl/sws_checker.sv
module sws_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic              wr_done
);

  p_oe_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n);

  p_we_needs_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce));

  p_ce_hold_at_we_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_ce_n) && $stable(mem_ce) && $stable(mem_addr)));

  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_drive_only_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_ce_n);

  p_drive_starts_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> !mem_we_n);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  p_ready_when_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (mem_ce_n && !mem_ce && mem_we_n));

endmodule

bind sram_wr_seq sws_checker #(.ADDR_W(ADDR_W)) u_sws_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_ce    (mem_ce),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .wr_done   (wr_done)
);

// File: tb/sram_wr_seq_tb_top.sv
module sram_wr_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Expected phase counts, written from the requirement formulas.
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // config 0: defaults; config 1: slow grade, 10 ns, 120 ns cycle, 15 ns hold
  int e_as [2], e_hz [2], e_sd [2], e_we [2], e_hd [2], e_rec [2];

  function automatic void calc(input int k, input int t, input int wc, input int sa,
                               input int aw, input int pw, input int sd, input int hd,
                               input int ha, input int hz);
    e_as[k]  = mx(1, cdiv(sa, t));
    e_hz[k]  = cdiv(hz, t);
    e_sd[k]  = mx(1, cdiv(sd, t));
    e_we[k]  = mx(mx(cdiv(pw, t), e_hz[k] + e_sd[k]), cdiv(aw, t) - e_as[k]);
    e_hd[k]  = cdiv(hd, t);
    e_rec[k] = mx(mx(1, cdiv(ha, t)), mx(e_hd[k], cdiv(wc, t) - e_as[k] - e_we[k]));
  endfunction

  logic [1:0]       vld;
  logic [1:0][16:0] iad;
  logic [1:0][7:0]  idt;
  logic [1:0]       rdy, cen, ce, wen, oen, dqoe, done;
  logic [1:0][16:0] mad;
  logic [1:0][7:0]  mdq;

  sram_wr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(vld[0]), .in_ready(rdy[0]),
    .in_addr(iad[0]), .in_data(idt[0]), .mem_addr(mad[0]), .mem_ce_n(cen[0]),
    .mem_ce(ce[0]), .mem_we_n(wen[0]), .mem_oe_n(oen[0]), .mem_dq_out(mdq[0]),
    .mem_dq_oe(dqoe[0]), .wr_done(done[0])
  );

  sram_wr_seq #(
    .CLK_PERIOD_NS(10), .CYCLE_MIN_NS(120), .ADDR_LEAD_NS(0), .ADDR_TO_END_NS(60),
    .WE_PULSE_NS(55), .DATA_SETUP_NS(30), .DATA_HOLD_NS(15), .ADDR_HOLD_NS(0),
    .FLOAT_NS(25)
  ) dut_slow_i (
    .clk(clk), .rst_n(rst_n), .in_valid(vld[1]), .in_ready(rdy[1]),
    .in_addr(iad[1]), .in_data(idt[1]), .mem_addr(mad[1]), .mem_ce_n(cen[1]),
    .mem_ce(ce[1]), .mem_we_n(wen[1]), .mem_oe_n(oen[1]), .mem_dq_out(mdq[1]),
    .mem_dq_oe(dqoe[1]), .wr_done(done[1])
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one write on instance k from the accepting edge to wr_done and checks
  // every phase length. Called at a negedge with the request already driven.
  task automatic run_write(input int k, input logic [16:0] a, input logic [7:0] d,
                           input bit keep_valid);
    int n_as = 0, n_we = 0, n_hz = 0, n_drv_lo = 0, n_rec = 0, n_hd = 0;
    int bad_addr = 0, bad_data = 0, bad_rdy = 0, bad_oe = 0;
    bit seen_low = 0, seen_drv = 0, got_done = 0;
    chk("R2", "ready before request", int'(rdy[k]), 1);
    @(negedge clk);
    if (!keep_valid) vld[k] = 1'b0;
    for (int i = 0; i < 100 && !got_done; i++) begin
      if (!oen[k]) bad_oe++;
      if (done[k]) begin
        got_done = 1;
      end else begin
        if (rdy[k]) bad_rdy++;
        if (mad[k] != a) bad_addr++;
        if (dqoe[k] && mdq[k] != d) bad_data++;
        if (!wen[k]) begin
          seen_low = 1; n_we++;
          if (dqoe[k]) begin seen_drv = 1; n_drv_lo++; end
          else if (!seen_drv) n_hz++;
        end else if (!seen_low) begin
          n_as++;
        end else begin
          n_rec++;
          if (dqoe[k]) n_hd++;
        end
        @(negedge clk);
      end
    end
    chk("R9", "wr_done reached", int'(got_done), 1);
    chk("R3", "address phase cycles", n_as, e_as[k]);
    chk("R4", "write-enable low cycles", n_we, e_we[k]);
    chk("R5", "float wait cycles", n_hz, e_hz[k]);
    chk("R5", "data driven while low", n_drv_lo, e_we[k] - e_hz[k]);
    chk("R5", "setup met", int'(n_drv_lo >= e_sd[k]), 1);
    chk("R5", "data driven after rise", n_hd, e_hd[k]);
    chk("R5", "data value mismatches", bad_data, 0);
    chk("R6", "recovery cycles", n_rec, e_rec[k]);
    chk("R10", "address mismatches", bad_addr, 0);
    chk("R2", "ready during write", bad_rdy, 0);
    chk("R8", "output enable low cycles", bad_oe, 0);
    chk("R9", "ce_n in done cycle", int'(cen[k]), 1);
    chk("R9", "ce in done cycle", int'(ce[k]), 0);
    chk("R9", "ready in done cycle", int'(rdy[k]), 1);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 2; k++) begin
      chk("R1", "ce_n", int'(cen[k]), 1);
      chk("R1", "ce", int'(ce[k]), 0);
      chk("R1", "we_n", int'(wen[k]), 1);
      chk("R1", "oe_n", int'(oen[k]), 1);
      chk("R1", "dq_oe", int'(dqoe[k]), 0);
      chk("R1", "done", int'(done[k]), 0);
      chk("R1", "ready", int'(rdy[k]), 1);
    end
  endtask

  task automatic t_single(input int k, input logic [16:0] a, input logic [7:0] d);
    vld[k] = 1'b1; iad[k] = a; idt[k] = d;
    run_write(k, a, d, 1'b0);
    @(negedge clk);
    chk("R9", "done lasts one cycle", int'(done[k]), 0);
  endtask

  task automatic t_back_to_back(input int k);
    vld[k] = 1'b1; iad[k] = 17'h0_0F0F; idt[k] = 8'h3C;
    run_write(k, 17'h0_0F0F, 8'h3C, 1'b1);
    iad[k] = 17'h1_F0F0; idt[k] = 8'hC3;
    @(negedge clk);
    chk("R9", "next write starts after done", int'(cen[k]), 0);
    chk("R9", "next address driven", int'(mad[k]), 17'h1_F0F0);
    vld[k] = 1'b0;
    // finish the second write: its address phase has begun already
    while (!done[k]) @(negedge clk);
    chk("R9", "second write done", int'(done[k]), 1);
    @(negedge clk);
  endtask

  task automatic t_ignore_busy(input int k);
    int changed = 0;
    vld[k] = 1'b1; iad[k] = 17'h0_1234; idt[k] = 8'h5A;
    @(negedge clk);
    vld[k] = 1'b0;
    for (int i = 0; i < 3; i++) begin
      iad[k] = 17'h1_AAAA + 17'(i); idt[k] = 8'hE0 + 8'(i);
      vld[k] = i[0];
      @(negedge clk);
      if (mad[k] != 17'h0_1234) changed++;
      if (dqoe[k] && mdq[k] != 8'h5A) changed++;
    end
    vld[k] = 1'b0;
    chk("R2", "pins changed by busy inputs", changed, 0);
    while (!done[k]) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!cen[k] || !wen[k]) changed++;
    end
    chk("R2", "write started by busy inputs", changed, 0);
    chk("R2", "address kept after idle", int'(mad[k]), 17'h0_1234);
  endtask

  task automatic t_no_valid(input int k);
    int act = 0;
    vld[k] = 1'b0; iad[k] = 17'h1_5555; idt[k] = 8'h77;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!cen[k] || ce[k] || !wen[k] || dqoe[k]) act++;
    end
    chk("R2", "activity without valid", act, 0);
  endtask

  initial begin
    calc(0, 20, 45, 0, 35, 35, 25, 0, 0, 15);
    calc(1, 10, 120, 0, 60, 55, 30, 15, 0, 25);
    vld = '0; iad = '0; idt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_valid(0);
    t_single(0, 17'h0_0000, 8'h00);
    t_single(0, 17'h1_FFFF, 8'hFF);
    t_single(1, 17'h0_ABCD, 8'hA5);
    t_single(1, 17'h1_FFFF, 8'h01);
    t_back_to_back(0);
    t_back_to_back(1);
    t_ignore_busy(0);
    t_ignore_busy(1);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule